// File: doc/BRIEF.md
# Programmable Level Flag Generator

This block produces three occupancy status flags for a dual-clock FIFO: half-full, almost-empty and almost-full. It does not hold the FIFO's storage and does not decide empty or full. Its inputs are the write and read pointers, one copy of each already synchronized into the write-clock domain and one into the read-clock domain, together with both port clocks. Occupancy is the wrapped difference of the two pointers. Each pointer carries one bit more than the address.

Two offset registers set where almost-empty and almost-full switch. Software can write either register in one write-clock cycle through a parallel load. It can also shift both registers in one bit at a time through a serial input.

While master reset is held, one input selects the timing scheme for the flags. In registered mode, every flag is a flop in a single clock domain. In split mode, each flag is raised by the clock of the port that moves the FIFO towards that flag's condition and lowered by the clock of the other port. A partial reset puts the flags back to their empty-FIFO values and leaves the offsets and the timing choice unchanged.

Top module: `fifo_level_flags`

## Requirements
- R1: Master reset (`mrst` high across a `wclk` rising edge) loads both offsets with `DEF_OFF` (default 7) and captures `async_sel` as the timing scheme (1 = split mode, 0 = registered mode). After reset the flags are almost-empty 1, almost-full 0 and half-full 0.
- R2: In registered mode, `flag_aempty` is updated only on `rclk` rising edges. It is set to 1 when the read-domain occupancy is less than or equal to the empty offset.
- R3: In registered mode, `flag_afull` is updated only on `wclk` rising edges. It is set to 1 when the write-domain free space (2^AW minus occupancy) is less than or equal to the full offset.
- R4: `flag_half` is 1 when the occupancy is greater than 2^(AW-1). In registered mode it is updated on `wclk`.
- R5: When `ld_en` is high on a `wclk` edge, `ld_data` is written to the empty offset if `ld_sel` is 0, or to the full offset if `ld_sel` is 1. A parallel load takes precedence over a serial shift in the same cycle.
- R6: When `ser_en` is high and `ld_en` is low, one bit of `ser_in` is shifted in per `wclk` edge. The bits arrive LSB first: AW bits for the empty offset, then AW bits for the full offset.
- R7: Partial reset (`prst`, held across edges of both clocks) forces almost-empty to 1, almost-full to 0 and half-full to 0. It leaves both offsets and the timing scheme unchanged.
- R8: In split mode, almost-full and half-full are raised only on `wclk` edges and lowered only on `rclk` edges.
- R9: In split mode, almost-empty is raised only on `rclk` edges and lowered only on `wclk` edges.
- R10: Changes on `async_sel` while `mrst` is low have no effect on the timing scheme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-port clock |
| rclk | input | 1 | Read-port clock |
| mrst | input | 1 | Master reset, active high, synchronous in each domain |
| prst | input | 1 | Partial reset, active high, synchronous in each domain |
| async_sel | input | 1 | Timing scheme select, sampled during master reset |
| wr_ptr_w | input | AW+1 | Write pointer, write-clock domain |
| rd_ptr_w | input | AW+1 | Read pointer synchronized to the write clock |
| wr_ptr_r | input | AW+1 | Write pointer synchronized to the read clock |
| rd_ptr_r | input | AW+1 | Read pointer, read-clock domain |
| ld_en | input | 1 | Parallel offset load strobe |
| ld_sel | input | 1 | Parallel load target: 0 empty offset, 1 full offset |
| ld_data | input | AW | Parallel load value |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| flag_half | output | 1 | Half-full flag |
| flag_aempty | output | 1 | Almost-empty flag |
| flag_afull | output | 1 | Almost-full flag |

## Verification
The assertions check, on every write-clock edge, the offset register behaviour: default values after master reset, the target of a parallel load, the serial shift order, and that the offsets are held through a partial reset. They also check that in registered mode almost-full never appears without half-full when the full offset is below half the depth. Which clock may move each flag can only be shown by the bench, which stops one clock and pulses the other. The same holds for the flag values against occupancy at the offset boundaries, the empty-state flags under a partial reset, and the timing scheme ignoring `async_sel` outside master reset.

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int AW      = 6,
  parameter int DEF_OFF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          async_sel,
  input  logic [AW:0]   wr_ptr_w,
  input  logic [AW:0]   rd_ptr_w,
  input  logic [AW:0]   wr_ptr_r,
  input  logic [AW:0]   rd_ptr_r,
  input  logic          ld_en,
  input  logic          ld_sel,
  input  logic [AW-1:0] ld_data,
  input  logic          ser_en,
  input  logic          ser_in,
  output logic          flag_half,
  output logic          flag_aempty,
  output logic          flag_afull
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1) << AW;
  localparam logic [PW-1:0] HALF  = DEPTH >> 1;

  logic          mode_async;
  logic [AW-1:0] e_off, f_off;

  wire [PW-1:0] occ_w = wr_ptr_w - rd_ptr_w;
  wire [PW-1:0] occ_r = wr_ptr_r - rd_ptr_r;

  wire ae_w = occ_w <= {1'b0, e_off};
  wire ae_r = occ_r <= {1'b0, e_off};
  wire af_w = (DEPTH - occ_w) <= {1'b0, f_off};
  wire af_r = (DEPTH - occ_r) <= {1'b0, f_off};
  wire hf_w = occ_w > HALF;
  wire hf_r = occ_r > HALF;

  // offsets and timing scheme live in the write domain
  always_ff @(posedge wclk) begin
    if (mrst) begin
      mode_async <= async_sel;
      e_off      <= AW'(DEF_OFF);
      f_off      <= AW'(DEF_OFF);
    end else if (ld_en) begin
      if (ld_sel) f_off <= ld_data;
      else        e_off <= ld_data;
    end else if (ser_en) begin
      {f_off, e_off} <= {ser_in, f_off, e_off[AW-1:1]};
    end
  end

  // registered scheme
  logic af_s, hf_s, ae_s;

  always_ff @(posedge wclk) begin
    if (mrst || prst) begin
      af_s <= 1'b0;
      hf_s <= 1'b0;
    end else begin
      af_s <= af_w;
      hf_s <= hf_w;
    end
  end

  always_ff @(posedge rclk) begin
    if (mrst || prst) ae_s <= 1'b1;
    else              ae_s <= ae_r;
  end

  // split scheme: flag = raise toggle ^ lower toggle, each toggle in one domain
  logic af_ts, af_tc, hf_ts, hf_tc, ae_ts, ae_tc;
  wire  af_a = af_ts ^ af_tc;
  wire  hf_a = hf_ts ^ hf_tc;
  wire  ae_a = ae_ts ^ ae_tc;

  always_ff @(posedge wclk) begin
    if (mrst || prst) begin
      af_ts <= 1'b0;
      hf_ts <= 1'b0;
      ae_tc <= 1'b0;
    end else if (mode_async) begin
      if (af_w && !af_a)  af_ts <= ~af_ts;
      if (hf_w && !hf_a)  hf_ts <= ~hf_ts;
      if (!ae_w && ae_a)  ae_tc <= ~ae_tc;
    end
  end

  always_ff @(posedge rclk) begin
    if (mrst || prst) begin
      af_tc <= 1'b0;
      hf_tc <= 1'b0;
      ae_ts <= 1'b1;
    end else if (mode_async) begin
      if (!af_r && af_a)  af_tc <= ~af_tc;
      if (!hf_r && hf_a)  hf_tc <= ~hf_tc;
      if (ae_r && !ae_a)  ae_ts <= ~ae_ts;
    end
  end

  assign flag_afull  = mode_async ? af_a : af_s;
  assign flag_half   = mode_async ? hf_a : hf_s;
  assign flag_aempty = mode_async ? ae_a : ae_s;

  assert_mrst_default_R1: assert property (@(posedge wclk) disable iff (prst)
    mrst |=> (e_off == AW'(DEF_OFF) && f_off == AW'(DEF_OFF)));

  assert_par_load_R5: assert property (@(posedge wclk) disable iff (mrst)
    (ld_en && !ld_sel) |=> (e_off == $past(ld_data)));

  assert_ser_order_R6: assert property (@(posedge wclk) disable iff (mrst)
    (ser_en && !ld_en) |=> (e_off[AW-1] == $past(f_off[0]) && f_off[AW-1] == $past(ser_in)));

  assert_prst_keep_R7: assert property (@(posedge wclk) disable iff (mrst)
    (prst && !ld_en && !ser_en) |=> ($stable(e_off) && $stable(f_off) && $stable(mode_async)));

  assert_full_implies_half_R4: assert property (@(posedge wclk) disable iff (mrst || prst)
    (!mode_async && ({1'b0, $past(f_off)} < HALF) && flag_afull) |-> flag_half);
endmodule

// File: tb/tb_fifo_level_flags.sv
module tb_fifo_level_flags;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int CLK_PERIOD = 10;

  logic wclk = 0, rclk = 0, mrst = 1, prst = 0, async_sel = 0;
  logic [AW:0] wr_ptr_w = 0, rd_ptr_w = 0, wr_ptr_r = 0, rd_ptr_r = 0;
  logic ld_en = 0, ld_sel = 0, ser_en = 0, ser_in = 0;
  logic [AW-1:0] ld_data = 0;
  logic flag_half, flag_aempty, flag_afull;

  int total = 0, bad = 0;
  int eo = 7, fo = 7;

  fifo_level_flags #(.AW(AW), .DEF_OFF(7)) dut (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .async_sel(async_sel),
    .wr_ptr_w(wr_ptr_w), .rd_ptr_w(rd_ptr_w), .wr_ptr_r(wr_ptr_r), .rd_ptr_r(rd_ptr_r),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .ser_en(ser_en), .ser_in(ser_in),
    .flag_half(flag_half), .flag_aempty(flag_aempty), .flag_afull(flag_afull));

  function automatic bit x_ae(int occ, int e); return occ <= e; endfunction
  function automatic bit x_af(int occ, int f); return (DEPTH - occ) <= f; endfunction
  function automatic bit x_hf(int occ); return occ > DEPTH / 2; endfunction

  task automatic tick_w(); #(CLK_PERIOD/2) wclk = 1; #(CLK_PERIOD/2) wclk = 0; endtask
  task automatic tick_r(); #(CLK_PERIOD/2) rclk = 1; #(CLK_PERIOD/2) rclk = 0; endtask
  task automatic both(int n); for (int i = 0; i < n; i++) begin tick_w(); tick_r(); end endtask

  task automatic set_occ(int occ);
    logic [AW:0] base = AW'($urandom_range(0, DEPTH - 1));
    wr_ptr_w = base + (AW+1)'(occ); wr_ptr_r = wr_ptr_w;
    rd_ptr_w = base;                rd_ptr_r = base;
  endtask

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_all(string req, int occ);
    chk({req, " aempty"}, flag_aempty, x_ae(occ, eo));
    chk({req, " afull"},  flag_afull,  x_af(occ, fo));
    chk({req, " half"},   flag_half,   x_hf(occ));
  endtask

  task automatic settle(string req, int occ); set_occ(occ); both(2); chk_all(req, occ); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: registered mode, reset state and default offsets
    both(3); mrst = 0;
    chk("R1 reset aempty", flag_aempty, 1); chk("R1 reset afull", flag_afull, 0);
    chk("R1 reset half", flag_half, 0);
    settle("R1 occ7", 7);  settle("R1 occ8", 8);
    settle("R1 occ57", 57); settle("R1 occ56", 56);
    settle("R4 occ32", 32); settle("R4 occ33", 33);
    set_occ(56); both(2);
    // R2/R3: domain of each registered flag
    set_occ(60); tick_w();
    chk("R3 afull on wclk", flag_afull, 1); chk("R4 half on wclk", flag_half, 1);
    set_occ(3); tick_w();
    chk("R3 afull clr wclk", flag_afull, 0); chk("R4 half clr wclk", flag_half, 0);
    chk("R2 aempty holds w/o rclk", flag_aempty, 0);
    tick_r(); chk("R2 aempty on rclk", flag_aempty, 1);
    set_occ(60); tick_r();
    chk("R2 aempty clr rclk", flag_aempty, 0); chk("R3 afull holds w/o wclk", flag_afull, 0);
    tick_w();
    // R5: parallel load
    ld_en = 1; ld_sel = 0; ld_data = 20; tick_w();
    ld_sel = 1; ld_data = 10; ser_en = 1; ser_in = 1; tick_w();
    ld_en = 0; ser_en = 0; eo = 20; fo = 10;
    settle("R5 occ20", 20); settle("R5 occ21", 21);
    settle("R5 occ54", 54); settle("R5 occ53", 53);
    // R6: serial load, empty offset first, LSB first
    begin
      logic [2*AW-1:0] bits = {6'd12, 6'd5};
      ser_en = 1;
      for (int i = 0; i < 2*AW; i++) begin ser_in = bits[i]; tick_w(); end
      ser_en = 0; eo = 5; fo = 12;
    end
    settle("R6 occ5", 5); settle("R6 occ6", 6);
    settle("R6 occ52", 52); settle("R6 occ51", 51);
    for (int k = 0; k < 40; k++) settle("R2/R3/R4 random sync", $urandom_range(0, DEPTH));
    // R7: partial reset
    set_occ(60); both(2);
    prst = 1; both(2);
    chk("R7 aempty", flag_aempty, 1); chk("R7 afull", flag_afull, 0); chk("R7 half", flag_half, 0);
    set_occ(0); prst = 0; async_sel = 1; both(2);
    settle("R7 keeps eo occ5", 5); settle("R7 keeps eo occ6", 6);
    settle("R7 keeps fo occ52", 52);
    // R10: mode unchanged by async_sel outside reset (still registered)
    set_occ(0); both(2);
    set_occ(60); tick_w();
    chk("R10 aempty not cleared by wclk", flag_aempty, 1);
    tick_r(); async_sel = 0;
    // R8/R9: split mode
    async_sel = 1; mrst = 1; both(3); mrst = 0; async_sel = 0; eo = 7; fo = 7;
    set_occ(0); both(1);
    chk("R1 split reset aempty", flag_aempty, 1);
    set_occ(60); tick_r();
    chk("R9 aempty not cleared by rclk", flag_aempty, 1);
    chk("R8 afull not raised by rclk", flag_afull, 0);
    chk("R8 half not raised by rclk", flag_half, 0);
    tick_w();
    chk("R9 aempty cleared by wclk", flag_aempty, 0);
    chk("R8 afull raised by wclk", flag_afull, 1);
    chk("R8 half raised by wclk", flag_half, 1);
    set_occ(2); tick_w();
    chk("R8 afull not lowered by wclk", flag_afull, 1);
    chk("R8 half not lowered by wclk", flag_half, 1);
    chk("R9 aempty not raised by wclk", flag_aempty, 0);
    tick_r();
    chk("R8 afull lowered by rclk", flag_afull, 0);
    chk("R8 half lowered by rclk", flag_half, 0);
    chk("R9 aempty raised by rclk", flag_aempty, 1);
    settle("R8/R9 occ7", 7); settle("R8/R9 occ8", 8); settle("R8/R9 occ57", 57);
    for (int k = 0; k < 40; k++) settle("R8/R9 random split", $urandom_range(0, DEPTH));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule